// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a synchronous binary counter built as a chain of identical nibble stages. It holds, loads a parallel value, or steps up or down by one on each rising clock edge. A terminal-count flag, called the ripple-carry output, rises when the count sits at its last value for the current direction and the counter is enabled. Each nibble stage produces this flag, and the next stage uses it as its count enable. Two stages give an 8-bit counter whose port behaviour is the same as that of one nibble.

An active-high clear input resets the count and the carry flag at once, with no clock edge needed. While a load is requested, every stage is enabled in the same edge, so the full parallel value lands in one cycle. The carry flag is a combinational function of the enable, the direction, the count and the clear. A further counter can therefore chain onto it without a cycle of delay.

Top module: `updown_cascade`

## Requirements
- R1: While `clear` is 1, `q` is 0 and `rco` is 0, without waiting for a clock edge.
- R2: With `enable`=0, `q` keeps its value across a rising edge, whatever `load`, `up` and `v` are.
- R3: With `enable`=1 and `load`=1, `q` takes `v` at the next rising edge, for either value of `up`.
- R4: With `enable`=1, `load`=0 and `up`=1, `q` increases by one at the next rising edge.
- R5: With `enable`=1, `load`=0 and `up`=0, `q` decreases by one at the next rising edge.
- R6: With `up`=1, `rco` is 1 exactly when `enable`=1 and `q`=8'hFF. This holds whatever the value of `load`.
- R7: With `up`=0, `rco` is 1 exactly when `enable`=1 and `q`=8'h00. When `enable`=0, or when `q` is any other value, `rco` is 0.
- R8: Counting wraps from 8'hFF to 8'h00 going up, and from 8'h00 to 8'hFF going down.
- R9: The low nibble (bits 3:0) carries into the high nibble (bits 7:4) in the same edge. Going up, 8'h0F becomes 8'h10. Going down, 8'h10 becomes 8'h0F. The high nibble moves only when the low nibble is at its terminal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Asynchronous active-high clear of count and carry |
| enable | input | 1 | Allows load or count; gates the carry |
| load | input | 1 | 1 loads `v`, 0 counts (when enabled) |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| v | input | 8 | Parallel load value |
| q | output | 8 | Current count |
| rco | output | 1 | Terminal-count flag for the current direction |

## Verification
A wrong count value shows on `q` in the same cycle. Because `rco` decodes `q` combinationally, a wrong count also changes `rco` the moment the terminal value is missed or reached falsely. A broken carry chain stays hidden until the low nibble crosses 4'hF or 4'h0. For that reason the sequences step across 8'h0F/8'h10 in both directions and run a long descent through 8'h00. A carry that ignores `enable` or `load` shows only at the terminal values, so those values are held with `enable` low and with `load` high.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;
endpackage

// File: rtl/ucnt_term.sv
module ucnt_term
    import ucnt_pkg::*;
#(
    parameter int NW = 4
) (
    input  logic [NW-1:0] cnt,
    input  logic          up,
    output logic          term
);
    dir_e dir;

    always_comb begin
        dir  = dir_e'(up);
        // Last value before a wrap in the present direction.
        term = (dir == DIR_UP) ? (&cnt) : ~(|cnt);
    end
endmodule

// File: rtl/ucnt_nibble.sv
module ucnt_nibble #(
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          clear,
    input  logic          cnt_en,
    input  logic          ld_en,
    input  logic          up,
    input  logic [NW-1:0] ld_val,
    output logic [NW-1:0] cnt_q,
    output logic          term
);
    typedef struct packed {
        logic [NW-1:0] cnt;
    } nib_state_t;

    nib_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_en) begin
            st_d.cnt = ld_val;
        end else if (cnt_en) begin
            st_d.cnt = up ? (st_q.cnt + 1'b1) : (st_q.cnt - 1'b1);
        end
    end

    always_ff @(posedge clk or posedge clear) begin
        if (clear) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;

    ucnt_term #(.NW(NW)) u_term (
        .cnt  (st_q.cnt),
        .up   (up),
        .term (term)
    );

    // R3 at stage level: a load strobe always wins over counting.
    a_r3_nib_load: assert property (@(posedge clk) disable iff (clear)
        ld_en |=> cnt_q == $past(ld_val));

    // R2 at stage level: no strobe, no change.
    a_r2_nib_hold: assert property (@(posedge clk) disable iff (clear)
        (!ld_en && !cnt_en) |=> $stable(cnt_q));
endmodule

// File: rtl/updown_cascade.sv
module updown_cascade #(
    parameter int NIB_W = 4,
    parameter int NIB_N = 2
) (
    input  logic                   clk,
    input  logic                   clear,
    input  logic                   enable,
    input  logic                   load,
    input  logic                   up,
    input  logic [NIB_W*NIB_N-1:0] v,
    output logic [NIB_W*NIB_N-1:0] q,
    output logic                   rco
);
    localparam int TOT_W = NIB_W * NIB_N;

    logic [NIB_N:0]   chain_en;
    logic [NIB_N-1:0] stage_term;
    logic             ld_all;

    assign ld_all      = enable & load;
    assign chain_en[0] = enable;

    for (genvar g = 0; g < NIB_N; g++) begin : g_stage
        ucnt_nibble #(.NW(NIB_W)) u_nib (
            .clk    (clk),
            .clear  (clear),
            .cnt_en (chain_en[g]),
            .ld_en  (ld_all),
            .up     (up),
            .ld_val (v[g*NIB_W +: NIB_W]),
            .cnt_q  (q[g*NIB_W +: NIB_W]),
            .term   (stage_term[g])
        );
        assign chain_en[g+1] = chain_en[g] & stage_term[g];
    end

    assign rco = ~clear & chain_en[NIB_N];

    a_r1_clear_zero: assert property (@(posedge clk)
        clear |-> (q == '0 && rco == 1'b0));

    a_r2_hold: assert property (@(posedge clk) disable iff (clear)
        !enable |=> $stable(q));

    a_r3_load: assert property (@(posedge clk) disable iff (clear)
        (enable && load) |=> q == $past(v));

    a_r4_count_up: assert property (@(posedge clk) disable iff (clear)
        (enable && !load && up) |=> q == TOT_W'($past(q) + 1'b1));

    a_r5_count_down: assert property (@(posedge clk) disable iff (clear)
        (enable && !load && !up) |=> q == TOT_W'($past(q) - 1'b1));

    a_r6_rco_at_top: assert property (@(posedge clk) disable iff (clear)
        (enable && up && q == '1) |-> rco);

    a_r7_rco_at_zero: assert property (@(posedge clk) disable iff (clear)
        (enable && !up && q == '0) |-> rco);

    a_r7_rco_only_terminal: assert property (@(posedge clk) disable iff (clear)
        rco |-> (enable && (up ? (q == '1) : (q == '0))));

    a_r8_wrap_up: assert property (@(posedge clk) disable iff (clear)
        (enable && !load && up && q == '1) |=> q == '0);

    a_r8_wrap_down: assert property (@(posedge clk) disable iff (clear)
        (enable && !load && !up && q == '0) |=> q == '1);

    a_r9_high_moves_on_carry: assert property (@(posedge clk) disable iff (clear)
        (enable && !load && q[NIB_W-1:0] != (up ? {NIB_W{1'b1}} : {NIB_W{1'b0}}))
        |=> $stable(q[TOT_W-1:NIB_W]));
endmodule

// File: tb/updown_cascade_bench.sv
`timescale 1ns/1ps
module updown_cascade_bench;
    logic       clk = 1'b0;
    logic       clear;
    logic       enable, load, up;
    logic [7:0] v;
    logic [7:0] q;
    logic       rco;

    int total = 0;
    int bad   = 0;
    logic [7:0] model;

    always #5 clk = ~clk;

    updown_cascade u_updown_cascade (
        .clk(clk), .clear(clear), .enable(enable), .load(load),
        .up(up), .v(v), .q(q), .rco(rco)
    );

    // Row: {enable, load, up, v[7:0], rco expected before edge, q expected after edge}
    localparam logic [19:0] VEC [0:13] = '{
        {1'b1, 1'b1, 1'b1, 8'h0E, 1'b0, 8'h0E}, // R3 load
        {1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h0F}, // R4 up
        {1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h10}, // R9 carry up
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h0F}, // R9 borrow down
        {1'b0, 1'b1, 1'b1, 8'h55, 1'b0, 8'h0F}, // R2 hold
        {1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, 8'hFF}, // R3 load, up ignored
        {1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00}, // R6 + R8 wrap up
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'hFF}, // R7 + R8 wrap down
        {1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 8'hFF}, // R6 gated by enable
        {1'b1, 1'b1, 1'b1, 8'h3C, 1'b1, 8'h3C}, // R6 during load
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h3B}, // R5 down
        {1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00}, // R3 load zero
        {1'b1, 1'b1, 1'b0, 8'hF0, 1'b1, 8'hF0}, // R7 during load
        {1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 8'hF1}  // R6 high nibble alone is not terminal
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at negedge, check rco before the edge, check q after it.
    task automatic step_model(input logic en_i, input logic ld_i, input logic up_i,
                              input logic [7:0] v_i, input string req);
        logic exp_rco;
        @(negedge clk);
        enable = en_i; load = ld_i; up = up_i; v = v_i;
        #1;
        exp_rco = en_i && (up_i ? (model == 8'hFF) : (model == 8'h00));
        check({req, " R6/R7 rco"}, int'(rco), int'(exp_rco));
        if (en_i && ld_i)      model = v_i;
        else if (en_i && up_i) model = model + 8'd1;
        else if (en_i)         model = model - 8'd1;
        @(posedge clk);
        #1;
        check({req, " q"}, int'(q), int'(model));
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear = 1'b1; enable = 1'b0; load = 1'b0; up = 1'b1; v = 8'h00;
        #1;
        check("R1 reset q", int'(q), 0);
        check("R1 reset rco", int'(rco), 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        clear = 1'b0;

        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            {enable, load, up, v} = VEC[i][19:9];
            #1;
            check($sformatf("R6/R7 rco row %0d", i), int'(rco), int'(VEC[i][8]));
            @(posedge clk);
            #1;
            check($sformatf("R2/R3/R4/R5/R8/R9 q row %0d", i), int'(q), int'(VEC[i][7:0]));
        end

        // R1: clear mid-cycle acts without an edge; down at zero must not raise rco.
        @(negedge clk);
        enable = 1'b1; load = 1'b0; up = 1'b0;
        #2 clear = 1'b1;
        #1;
        check("R1 async q", int'(q), 0);
        check("R1 async rco", int'(rco), 0);
        @(negedge clk);
        clear = 1'b0;
        enable = 1'b0;
        model = 8'h00;

        // Load 10, six steps down, twenty up.
        step_model(1'b1, 1'b1, 1'b0, 8'd10, "R3 load 10");
        for (int i = 0; i < 6; i++)  step_model(1'b1, 1'b0, 1'b0, 8'h00, "R5 down");
        for (int i = 0; i < 20; i++) step_model(1'b1, 1'b0, 1'b1, 8'h00, "R4/R9 up");

        // Load 122, 124 steps down: crosses 00 -> FF (R8).
        step_model(1'b1, 1'b1, 1'b1, 8'd122, "R3 load 122");
        for (int i = 0; i < 124; i++) step_model(1'b1, 1'b0, 1'b0, 8'h00, "R5/R8 down");
        check("R8 final after underflow", int'(q), 8'hFE);

        // R2: disabled hold with changing other inputs.
        step_model(1'b0, 1'b1, 1'b1, 8'hA5, "R2 hold");
        step_model(1'b0, 1'b0, 1'b0, 8'h5A, "R2 hold");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule